// File: doc/BRIEF.md
# Selectable-Polynomial Byte CRC Engine

This block keeps a running cyclic redundancy check over a message delivered one byte per clock. Each byte marked valid is folded into a 16-bit state register in a single cycle, so a message of any length is hashed by streaming its bytes back to back. Between messages the controller issues a clear, which zeroes the state and sets the arithmetic for the next message.

The arithmetic is chosen from one 8-bit generator and two 16-bit generators. A bit-order select matches the CRC to the order in which a serial link sends its bits. In msb-first order each byte is consumed from bit 7 down, using the generator in its normal form. In lsb-first order each byte is consumed from bit 0 up, using the bit-reversed generator.

The polynomial code and the bit-order select are sampled only on a clear. Between clears they may change freely without disturbing a message that is in progress. No final inversion is applied: the output is the state register itself.

Top module: `crc_multi_gen`

## Requirements
- R1: While reset is active, and right after it, crcOut reads 0. The active configuration after reset is polynomial code 0 in msb-first order.
- R2: clear=1 at a clock edge zeroes the state, so crcOut reads 0 after that edge. That edge also latches polySel and lsbFirst. clear takes priority over dataValid in the same cycle, and the byte is dropped.
- R3: polySel code 0 selects x^8+x^2+x+1 (normal 0x07, reflected 0xE0) with an 8-bit state. crcOut[15:8] then always reads 0.
- R4: polySel code 1 selects x^16+x^15+x^2+1 (normal 0x8005, reflected 0xA001) with a 16-bit state.
- R5: polySel codes 2 and 3 both select x^16+x^12+x^5+1 (normal 0x1021, reflected 0x8408) with a 16-bit state.
- R6: With lsbFirst=0 each byte is processed bit 7 first against the normal generator. With lsbFirst=1 it is processed bit 0 first against the reflected generator. From a zero state, the ASCII message "123456789" gives these results: code 0 msb 0xF4; code 1 msb 0xFEE8; code 1 lsb 0xBB3D; code 2 msb 0x31C3; code 2 lsb 0x2189.
- R7: A byte presented with dataValid=1 at a clock edge is reflected in crcOut right after that edge. Bytes may arrive on every consecutive cycle with no stall.
- R8: With dataValid=0 and clear=0, crcOut holds its value.
- R9: Changes to polySel or lsbFirst without a clear have no effect on the running CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero the state and latch the configuration |
| polySel | input | 2 | Generator code, sampled on clear |
| lsbFirst | input | 1 | 1 = reflected (lsb-first), sampled on clear |
| dataValid | input | 1 | dataIn holds a byte to absorb |
| dataIn | input | 8 | Message byte |
| crcOut | output | 16 | Running CRC (upper byte zero in 8-bit mode) |

## Verification
The standard nine-byte check string is run through every polynomial code, in both bit orders where a known value exists. Each known value tells apart a wrong generator, a wrong feedback tap, and a swapped bit order. A pseudo-random stream in 8-bit lsb-first mode is compared against an independent model. That stream shows that the reflected 8-bit path shifts within the narrow width and leaves the upper byte clear. Directed sequences cover three further cases. Idle gaps tell a hold apart from a spurious update. Select changes in mid-message tell sampled configuration apart from live configuration. A clear arriving together with a byte shows which of the two wins.

// File: rtl/crc_gen_pkg.sv
package crc_gen_pkg;
  localparam int CRC_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int NARROW_W = 8;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    POLY_N8   = 2'd0,
    POLY_A16  = 2'd1,
    POLY_C16  = 2'd2,
    POLY_C16B = 2'd3
  } poly_e;

  typedef struct packed {
    logic clr;
    logic upd;
  } strobe_t;

  typedef struct packed {
    poly_e poly;
    logic  lsbFirst;
  } cfg_t;

  function automatic logic isNarrow(poly_e p);
    return p == POLY_N8;
  endfunction

  function automatic logic [CRC_W-1:0] polyNormal(poly_e p);
    case (p)
      POLY_N8:  return 16'h0007;
      POLY_A16: return 16'h8005;
      default:  return 16'h1021;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] polyReflected(poly_e p);
    case (p)
      POLY_N8:  return 16'h00E0;
      POLY_A16: return 16'hA001;
      default:  return 16'h8408;
    endcase
  endfunction
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic [SEL_W-1:0] polySel,
  input  logic             lsbFirst,
  input  logic             dataValid,
  output strobe_t          strobes,
  output cfg_t             cfg
);
  cfg_t cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg.poly     <= POLY_N8;
      cfgReg.lsbFirst <= 1'b0;
    end else if (clear) begin
      cfgReg.poly     <= poly_e'(polySel);
      cfgReg.lsbFirst <= lsbFirst;
    end
  end

  always_comb begin
    strobes.clr = clear;
    strobes.upd = dataValid & ~clear;
  end

  assign cfg = cfgReg;

  // R9: configuration moves only on a clear
  assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> $stable(cfgReg));
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  cfg_t              cfg,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcState
);
  localparam logic [CRC_W-1:0] NARROW_MASK = CRC_W'((1 << NARROW_W) - 1);

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcNext;
  logic [CRC_W-1:0] genNorm;
  logic [CRC_W-1:0] genRefl;
  logic             narrow;

  always_comb begin
    narrow  = isNarrow(cfg.poly);
    genNorm = polyNormal(cfg.poly);
    genRefl = polyReflected(cfg.poly);
  end

  always_comb begin
    logic fb;
    crcNext = crcReg;
    for (int i = 0; i < BYTE_W; i++) begin
      if (cfg.lsbFirst) begin
        fb      = crcNext[0] ^ dataIn[i];
        crcNext = crcNext >> 1;
        if (fb) crcNext = crcNext ^ genRefl;
      end else begin
        fb      = (narrow ? crcNext[NARROW_W-1] : crcNext[CRC_W-1]) ^ dataIn[BYTE_W-1-i];
        crcNext = crcNext << 1;
        if (fb) crcNext = crcNext ^ genNorm;
      end
    end
    if (narrow) crcNext = crcNext & NARROW_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            crcReg <= '0;
    else if (strobes.clr) crcReg <= '0;
    else if (strobes.upd) crcReg <= crcNext;
  end

  assign crcState = crcReg;

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> crcReg == '0);
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clr && !strobes.upd |=> $stable(crcReg));
  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    narrow |-> crcReg[CRC_W-1:NARROW_W] == '0);
  assert_update_uses_next_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.upd |=> crcReg == $past(crcNext));
endmodule

// File: rtl/crc_multi_gen.sv
module crc_multi_gen
  import crc_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic [SEL_W-1:0]  polySel,
  input  logic              lsbFirst,
  input  logic              dataValid,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);
  strobe_t strobes;
  cfg_t    cfg;

  crc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .clear(clear), .polySel(polySel),
    .lsbFirst(lsbFirst), .dataValid(dataValid), .strobes(strobes), .cfg(cfg)
  );

  crc_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfg(cfg),
    .dataIn(dataIn), .crcState(crcOut)
  );

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |-> crcOut == '0);
endmodule

// File: tb/crc_multi_gen_tb.sv
module crc_multi_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  // {polySel, lsbFirst, expected}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 16'h00F4},
    {2'd1, 1'b0, 16'hFEE8},
    {2'd1, 1'b1, 16'hBB3D},
    {2'd2, 1'b0, 16'h31C3},
    {2'd2, 1'b1, 16'h2189},
    {2'd3, 1'b0, 16'h31C3}
  };
  localparam logic [7:0] MSG [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                     8'h36, 8'h37, 8'h38, 8'h39};

  logic        clk = 0;
  logic        rstN = 0;
  logic        clear = 0;
  logic [1:0]  polySel = 0;
  logic        lsbFirst = 0;
  logic        dataValid = 0;
  logic [7:0]  dataIn = 0;
  logic [15:0] crcOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 0;

  crc_multi_gen dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .polySel(polySel),
    .lsbFirst(lsbFirst), .dataValid(dataValid), .dataIn(dataIn), .crcOut(crcOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] refStep(logic [15:0] c, logic [7:0] d,
                                          logic [1:0] code, bit refl);
    int w = (code == 2'd0) ? 8 : 16;
    logic [15:0] p = (code == 2'd0) ? 16'h0007 : (code == 2'd1) ? 16'h8005 : 16'h1021;
    logic [15:0] rp = '0;
    logic [15:0] m = (w == 8) ? 16'h00FF : 16'hFFFF;
    for (int k = 0; k < w; k++) rp[w-1-k] = p[k];
    if (refl) begin
      c = c ^ {8'h00, d};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
    end else begin
      c = c ^ ({8'h00, d} << (w - 8));
      for (int k = 0; k < 8; k++) c = c[w-1] ? (((c << 1) ^ p) & m) : ((c << 1) & m);
    end
    return c & m;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: crcOut=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doClear(logic [1:0] code, bit refl, bit withByte = 0);
    @(negedge clk);
    polySel = code; lsbFirst = refl; clear = 1;
    dataValid = withByte; dataIn = 8'hA5;
    @(negedge clk);
    clear = 0; dataValid = 0;
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk);
    dataIn = b; dataValid = 1;
  endtask

  task automatic endBurst();
    @(negedge clk);
    dataValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] model;
    logic [15:0] held;
    logic [7:0]  lfsr;
    #(CLK_PERIOD * 2.3);
    check("R1 during reset", crcOut, 16'h0000);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check("R1 after reset", crcOut, 16'h0000);

    // R1: default config is code 0 msb-first, no clear issued
    sendByte(8'h31); endBurst();
    check("R1 default config", crcOut, refStep(16'h0, 8'h31, 2'd0, 0));

    // R3 R4 R5 R6 R7: table of check-string results
    for (int v = 0; v < NVEC; v++) begin
      doClear(VEC[v][18:17], VEC[v][16]);
      for (int b = 0; b < 9; b++) sendByte(MSG[b]);
      endBurst();
      check($sformatf("R6 vector %0d (R3/R4/R5)", v), crcOut, VEC[v][15:0]);
    end

    // R3: 8-bit lsb-first, pseudo-random stream, upper byte zero
    doClear(2'd0, 1);
    model = '0; lfsr = 8'h5C;
    for (int b = 0; b < 20; b++) begin
      sendByte(lfsr);
      model = refStep(model, lfsr, 2'd0, 1);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    endBurst();
    check("R3 narrow reflected stream", crcOut, model);
    check("R3 upper byte zero", {crcOut[15:8], 8'h00}, 16'h0000);

    // R7: single byte visible right after its edge
    doClear(2'd1, 0);
    sendByte(8'hFF); endBurst();
    check("R7 single byte", crcOut, refStep(16'h0, 8'hFF, 2'd1, 0));

    // R8: idle cycles hold state
    held = crcOut;
    @(negedge clk); dataIn = 8'h77;
    repeat (4) @(negedge clk);
    check("R8 hold while idle", crcOut, held);

    // R9: select change mid-message without clear is ignored
    doClear(2'd1, 0);
    model = '0;
    sendByte(8'h12); model = refStep(model, 8'h12, 2'd1, 0);
    polySel = 2'd2; lsbFirst = 1;
    sendByte(8'h34); model = refStep(model, 8'h34, 2'd1, 0);
    sendByte(8'h56); model = refStep(model, 8'h56, 2'd1, 0);
    endBurst();
    check("R9 config ignored without clear", crcOut, model);

    // R2: clear mid-message zeroes, byte alongside clear dropped
    doClear(2'd2, 0, 1);
    check("R2 clear beats byte", crcOut, 16'h0000);
    sendByte(8'h31); endBurst();
    check("R2 clear latched new config", crcOut, refStep(16'h0, 8'h31, 2'd2, 0));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule